// File: doc/BRIEF.md
# Shared Channel Parameter Memory with Coherent Pairs

This block is the parameter store that sits between a host bus and a timing engine. It holds sixteen-bit parameter words grouped per channel. Each channel owns a window of `SLOT_WORDS` word addresses, and the window starts at `channel * SLOT_WORDS`. In the default layout, channels below `FULL_FROM` implement only their first `BASE_WORDS` slots. The channels from `FULL_FROM` upward implement the whole window. Setting `ALL_FULL` makes every slot of every channel real.

Two ports share one storage path:

- **Host port:** makes word accesses and long-word (pair) accesses.
- **Engine port:** makes word accesses and coherent double-word (pair) accesses.

Both ports use the same handshake. A requester holds `req` and its command until its `wait` output is low at a rising clock edge. A pair access covers the even-aligned word pair that contains the address. The port serves the even word in the first cycle and the odd word in the second cycle. During both cycles the opposite port is held off, so a pair is never seen half-updated.

When both ports request in the same idle cycle, the engine is served first. A host that has lost arbitration is then served before any further engine request. Slots that are not implemented read as zero, and writes to them change nothing.

Top module: `par_ram_dp`

## Requirements
- R1: After reset both `wait` outputs are low, both `rdata` outputs are zero, and every word reads zero.
- R2: A word write stores `wdata[15:0]` at `addr`. A later word read returns that word in `rdata[15:0]` with `rdata[31:16]` zero, one cycle after the accepting edge.
- R3: A pair access uses word address `{addr[6:1],0}` for `rdata/wdata[15:0]` and `{addr[6:1],1}` for bits `[31:16]`. Address bit 0 is ignored.
- R4: With no competing request, a word access is accepted with zero wait cycles. A pair access shows `wait` high for exactly one cycle and completes in the second cycle.
- R5: While a pair access from one port is in its second cycle, a request from the other port sees `wait` high. Reads therefore return either the whole old pair or the whole new pair.
- R6: When both ports request in the same idle cycle and the host holds no priority, the engine access proceeds and the host waits.
- R7: A host that waited because of an engine access is served next, even if the engine keeps requesting. The host waits for at most one engine access plus its own pair first cycle, which is at most three cycles.
- R8: Channel c slot s lives at word address `c*8+s`. In the default layout, slots 0 to 5 of channels 0 to 13 and slots 0 to 7 of channels 14 and 15 are implemented.
- R9: Reads of unimplemented slots (slots 6 and 7 of channels 0 to 13) return zero in the corresponding half.
- R10: Word or pair writes to unimplemented slots are ignored and change no implemented word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host request, held until accepted |
| h_we | input | 1 | Host write (1) or read (0) |
| h_pair | input | 1 | Host long-word pair access |
| h_addr | input | 7 | Host word address |
| h_wdata | input | 32 | Host write data (high half used only for pairs) |
| h_wait | output | 1 | Host must hold its request another cycle |
| h_rdata | output | 32 | Host read data, registered |
| e_req | input | 1 | Engine request, held until accepted |
| e_we | input | 1 | Engine write (1) or read (0) |
| e_pair | input | 1 | Engine coherent double-word access |
| e_addr | input | 7 | Engine word address |
| e_wdata | input | 32 | Engine write data |
| e_wait | output | 1 | Engine must hold its request another cycle |
| e_rdata | output | 32 | Engine read data, registered |

## Verification
`wait` is combinational from the current request and the arbiter state. The bench drives at the falling edge and reads `wait` one nanosecond later, in the same cycle. Read data is registered on the accepting rising edge and is due at the next falling edge, where the bench samples it. Wait counts are compared with directed expectations:

- zero for an idle word access;
- one for a pair;
- one for a host losing to an engine word;
- three for a host pair behind an engine pair.

Random single-port traffic is checked against a bench model of the slot map.

// File: rtl/par_ram_pkg.sv
package par_ram_pkg;

  typedef enum logic {
    OWN_HOST = 1'b0,
    OWN_ENG  = 1'b1
  } owner_e;

  // True when word address waddr maps to an implemented slot.
  function automatic logic word_present(
    input int unsigned waddr,
    input int unsigned slot_words,
    input int unsigned base_words,
    input int unsigned full_from,
    input bit          all_full
  );
    int unsigned chan;
    int unsigned slot;
    chan = waddr / slot_words;
    slot = waddr % slot_words;
    return all_full || (chan >= full_from) || (slot < base_words);
  endfunction

endpackage

// File: rtl/par_ram_arb.sv
module par_ram_arb
  import par_ram_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   h_req,
  input  logic   h_pair,
  input  logic   e_req,
  input  logic   e_pair,
  output logic   act,
  output owner_e own,
  output logic   ph2,
  output logic   first,
  output logic   h_done,
  output logic   e_done,
  output logic   h_prio
);

  logic   ph2_q;
  logic   hprio_q;
  owner_e own_q;
  logic   sel_pair;
  logic   done;

  always_comb begin
    act = 1'b0;
    own = OWN_HOST;
    if (ph2_q) begin
      act = 1'b1;
      own = own_q;
    end else if (h_req && (!e_req || hprio_q)) begin
      act = 1'b1;
      own = OWN_HOST;
    end else if (e_req) begin
      act = 1'b1;
      own = OWN_ENG;
    end
  end

  assign sel_pair = (own == OWN_ENG) ? e_pair : h_pair;
  assign first    = act && !ph2_q && sel_pair;
  assign done     = act && (ph2_q || !sel_pair);
  assign h_done   = done && (own == OWN_HOST);
  assign e_done   = done && (own == OWN_ENG);
  assign ph2      = ph2_q;
  assign h_prio   = hprio_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph2_q   <= 1'b0;
      own_q   <= OWN_HOST;
      hprio_q <= 1'b0;
    end else begin
      ph2_q   <= first;
      own_q   <= own;
      hprio_q <= h_req && !h_done;
    end
  end

endmodule

// File: rtl/par_ram_store.sv
module par_ram_store
  import par_ram_pkg::*;
#(
  parameter int unsigned DEPTH      = 128,
  parameter int unsigned SLOT_WORDS = 8,
  parameter int unsigned BASE_WORDS = 6,
  parameter int unsigned FULL_FROM  = 14,
  parameter bit          ALL_FULL   = 1'b0,
  parameter int unsigned DW         = 16,
  localparam int unsigned AW        = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_addr,
  input  logic            wr_en,
  input  logic            wr_pair,
  input  logic [AW-1:0]   wr_addr,
  input  logic [2*DW-1:0] wr_data,
  output logic [DW-1:0]   rd_word
);

  logic [DEPTH-1:0][DW-1:0] cells;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    if (word_present(gi, SLOT_WORDS, BASE_WORDS, FULL_FROM, ALL_FULL)) begin : g_real
      localparam bit ODD = (gi % 2) == 1;
      logic          hit;
      logic [DW-1:0] cell_q;
      assign hit = wr_en && (wr_pair ? (wr_addr[AW-1:1] == (AW-1)'(gi / 2))
                                     : (wr_addr == AW'(gi)));
      always_ff @(posedge clk) begin
        if (!rst_n)   cell_q <= '0;
        else if (hit) cell_q <= (wr_pair && ODD) ? wr_data[2*DW-1:DW] : wr_data[DW-1:0];
      end
      assign cells[gi] = cell_q;
    end else begin : g_void
      assign cells[gi] = '0;
    end
  end

  assign rd_word = cells[rd_addr];

endmodule

// File: rtl/par_ram_dp.sv
module par_ram_dp
  import par_ram_pkg::*;
#(
  parameter int unsigned CH_NUM     = 16,
  parameter int unsigned SLOT_WORDS = 8,
  parameter int unsigned BASE_WORDS = 6,
  parameter int unsigned FULL_FROM  = 14,
  parameter bit          ALL_FULL   = 1'b0,
  parameter int unsigned DW         = 16,
  localparam int unsigned DEPTH     = CH_NUM * SLOT_WORDS,
  localparam int unsigned AW        = $clog2(DEPTH),
  localparam int unsigned LW        = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_req,
  input  logic          h_we,
  input  logic          h_pair,
  input  logic [AW-1:0] h_addr,
  input  logic [LW-1:0] h_wdata,
  output logic          h_wait,
  output logic [LW-1:0] h_rdata,
  input  logic          e_req,
  input  logic          e_we,
  input  logic          e_pair,
  input  logic [AW-1:0] e_addr,
  input  logic [LW-1:0] e_wdata,
  output logic          e_wait,
  output logic [LW-1:0] e_rdata
);

  // Internal events, brought out for the checker.
  logic   act, ph2, first, h_done, e_done, h_prio;
  owner_e own;

  logic          s_we, s_pair;
  logic [AW-1:0] s_addr, rd_addr;
  logic [LW-1:0] s_wdata, rd_result;
  logic [DW-1:0] rd_word, hold_lo_q;
  logic          wr_en;
  logic [LW-1:0] h_rdata_q, e_rdata_q;

  par_ram_arb u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .h_req  (h_req),
    .h_pair (h_pair),
    .e_req  (e_req),
    .e_pair (e_pair),
    .act    (act),
    .own    (own),
    .ph2    (ph2),
    .first  (first),
    .h_done (h_done),
    .e_done (e_done),
    .h_prio (h_prio)
  );

  assign s_we    = (own == OWN_ENG) ? e_we    : h_we;
  assign s_pair  = (own == OWN_ENG) ? e_pair  : h_pair;
  assign s_addr  = (own == OWN_ENG) ? e_addr  : h_addr;
  assign s_wdata = (own == OWN_ENG) ? e_wdata : h_wdata;

  assign rd_addr   = s_pair ? {s_addr[AW-1:1], ph2} : s_addr;
  assign wr_en     = (h_done || e_done) && s_we;
  assign rd_result = s_pair ? {rd_word, hold_lo_q} : {{DW{1'b0}}, rd_word};

  par_ram_store #(
    .DEPTH      (DEPTH),
    .SLOT_WORDS (SLOT_WORDS),
    .BASE_WORDS (BASE_WORDS),
    .FULL_FROM  (FULL_FROM),
    .ALL_FULL   (ALL_FULL),
    .DW         (DW)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_pair (s_pair),
    .wr_addr (s_addr),
    .wr_data (s_wdata),
    .rd_word (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_lo_q <= '0;
      h_rdata_q <= '0;
      e_rdata_q <= '0;
    end else begin
      if (first)           hold_lo_q <= rd_word;
      if (h_done && !h_we) h_rdata_q <= rd_result;
      if (e_done && !e_we) e_rdata_q <= rd_result;
    end
  end

  assign h_wait  = h_req && !h_done;
  assign e_wait  = e_req && !e_done;
  assign h_rdata = h_rdata_q;
  assign e_rdata = e_rdata_q;

endmodule

// File: rtl/par_ram_chk.sv
module par_ram_chk
  import par_ram_pkg::*;
#(
  parameter int unsigned SLOT_WORDS = 8,
  parameter int unsigned BASE_WORDS = 6,
  parameter int unsigned FULL_FROM  = 14,
  parameter bit          ALL_FULL   = 1'b0,
  parameter int unsigned AW         = 7,
  parameter int unsigned LW         = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_req,
  input logic          h_we,
  input logic          h_pair,
  input logic [AW-1:0] h_addr,
  input logic          h_wait,
  input logic [LW-1:0] h_rdata,
  input logic          e_req,
  input logic          e_pair,
  input logic          e_wait,
  input logic          first,
  input logic          ph2,
  input owner_e        own,
  input logic          h_done,
  input logic          e_done,
  input logic          h_prio
);

  logic [2:0] hwait_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        hwait_run_q <= '0;
    else if (!h_wait)  hwait_run_q <= '0;
    else if (hwait_run_q != 3'd7) hwait_run_q <= hwait_run_q + 3'd1;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_done && e_done)); // R6

  AST_WORD_NOWAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_pair && !e_req && !ph2) |-> !h_wait); // R4

  AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    first |=> (ph2 && (h_done || e_done))); // R4

  AST_ENG_LOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2 && own == OWN_ENG && h_req) |-> h_wait); // R5

  AST_HOST_LOCKS_ENG: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2 && own == OWN_HOST && e_req) |-> e_wait); // R5

  AST_ENG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && e_req && !ph2 && !h_prio) |-> (h_wait && !h_done)); // R6

  AST_HOST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    h_wait |-> (hwait_run_q < 3'd3)); // R7

  AST_VOID_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (h_done && !h_we && !h_pair &&
     !word_present(int'(h_addr), SLOT_WORDS, BASE_WORDS, FULL_FROM, ALL_FULL))
    |=> (h_rdata == '0)); // R9

endmodule

bind par_ram_dp par_ram_chk #(
  .SLOT_WORDS (SLOT_WORDS),
  .BASE_WORDS (BASE_WORDS),
  .FULL_FROM  (FULL_FROM),
  .ALL_FULL   (ALL_FULL),
  .AW         (AW),
  .LW         (LW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .h_req   (h_req),
  .h_we    (h_we),
  .h_pair  (h_pair),
  .h_addr  (h_addr),
  .h_wait  (h_wait),
  .h_rdata (h_rdata),
  .e_req   (e_req),
  .e_pair  (e_pair),
  .e_wait  (e_wait),
  .first   (first),
  .ph2     (ph2),
  .own     (own),
  .h_done  (h_done),
  .e_done  (e_done),
  .h_prio  (h_prio)
);

// File: tb/par_ram_dp_tb_top.sv
`timescale 1ns/1ps
module par_ram_dp_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 0, h_we = 0, h_pair = 0;
  logic [6:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic        h_wait;
  logic [31:0] h_rdata;
  logic        e_req = 0, e_we = 0, e_pair = 0;
  logic [6:0]  e_addr = '0;
  logic [31:0] e_wdata = '0;
  logic        e_wait;
  logic [31:0] e_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] ref_m [128];

  always #2 clk = ~clk;

  par_ram_dp dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_req(h_req), .h_we(h_we), .h_pair(h_pair), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_wait(h_wait), .h_rdata(h_rdata),
    .e_req(e_req), .e_we(e_we), .e_pair(e_pair), .e_addr(e_addr),
    .e_wdata(e_wdata), .e_wait(e_wait), .e_rdata(e_rdata)
  );

  function automatic bit b_real(int a);
    return ((a / 8) >= 14) || ((a % 8) < 6);
  endfunction

  function automatic logic [31:0] b_expect(bit pair, int a);
    int lo;
    if (!pair) return {16'h0, ref_m[a]};
    lo = a - (a % 2);
    return {ref_m[lo + 1], ref_m[lo]};
  endfunction

  function automatic void b_write(bit pair, int a, logic [31:0] d);
    int lo;
    if (!pair) begin
      if (b_real(a)) ref_m[a] = d[15:0];
    end else begin
      lo = a - (a % 2);
      if (b_real(lo))     ref_m[lo]     = d[15:0];
      if (b_real(lo + 1)) ref_m[lo + 1] = d[31:16];
    end
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic h_op(input int lag, input bit we, input bit pair, input int a,
                      input logic [31:0] d, output logic [31:0] rd, output int waits);
    repeat (lag) @(negedge clk);
    @(negedge clk);
    h_req = 1; h_we = we; h_pair = pair; h_addr = 7'(a); h_wdata = d; waits = 0;
    #1;
    while (h_wait) begin waits++; @(negedge clk); #1; end
    @(negedge clk);
    h_req = 0;
    rd = h_rdata;
  endtask

  task automatic e_op(input int lag, input bit we, input bit pair, input int a,
                      input logic [31:0] d, output logic [31:0] rd, output int waits);
    repeat (lag) @(negedge clk);
    @(negedge clk);
    e_req = 1; e_we = we; e_pair = pair; e_addr = 7'(a); e_wdata = d; waits = 0;
    #1;
    while (e_wait) begin waits++; @(negedge clk); #1; end
    @(negedge clk);
    e_req = 0;
    rd = e_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog expired act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, rd2;
    int w, w2;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 128; i++) ref_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk(!h_wait && !e_wait, "R1 waits", {h_wait, e_wait}, 0);
    chk(h_rdata == 0 && e_rdata == 0, "R1 rdata", h_rdata | e_rdata, 0);
    h_op(0, 0, 1, 116, 0, rd, w);
    chk(rd == 0, "R1 pair reads zero", rd, 0);

    // R2/R4: word write and read
    h_op(0, 1, 0, 26, 32'hFFFF_BEEF, rd, w);
    b_write(0, 26, 32'hFFFF_BEEF);
    chk(w == 0, "R4 word write no wait", w, 0);
    h_op(0, 0, 0, 26, 0, rd, w);
    chk(rd == 32'h0000_BEEF, "R2 word readback", rd, 32'h0000_BEEF);

    // R3/R4: pair at odd address
    h_op(0, 1, 1, 17, 32'hC0DE_F00D, rd, w);
    b_write(1, 17, 32'hC0DE_F00D);
    chk(w == 1, "R4 pair one wait", w, 1);
    e_op(0, 0, 0, 16, 0, rd, w);
    chk(rd == 32'h0000_F00D, "R3 even word low half", rd, 32'h0000_F00D);
    e_op(0, 0, 0, 17, 0, rd, w);
    chk(rd == 32'h0000_C0DE, "R3 odd word high half", rd, 32'h0000_C0DE);

    // R6: simultaneous word writes, engine first then host
    fork
      h_op(0, 1, 0, 40, 32'h1111, rd, w);
      e_op(0, 1, 0, 40, 32'h2222, rd2, w2);
    join
    b_write(0, 40, 32'h1111);
    chk(w2 == 0, "R6 engine no wait", w2, 0);
    chk(w == 1, "R6 host waits", w, 1);
    h_op(0, 0, 0, 40, 0, rd, w);
    chk(rd == 32'h1111, "R6 host write lands last", rd, 32'h1111);

    // R5: engine pair write vs host pair read of the same pair
    h_op(0, 1, 1, 48, 32'hAAAA_5555, rd, w);
    b_write(1, 48, 32'hAAAA_5555);
    fork
      e_op(0, 1, 1, 48, 32'h1234_ABCD, rd2, w2);
      h_op(0, 0, 1, 49, 0, rd, w);
    join
    b_write(1, 48, 32'h1234_ABCD);
    chk(w == 3, "R5 host held through engine pair", w, 3);
    chk(rd == 32'h1234_ABCD, "R5 coherent pair", rd, 32'h1234_ABCD);

    // R5: engine word read during host pair second cycle
    fork
      h_op(0, 1, 1, 50, 32'h7654_3210, rd, w);
      e_op(1, 0, 0, 51, 0, rd2, w2);
    join
    b_write(1, 50, 32'h7654_3210);
    chk(w2 == 1, "R5 engine held in pair", w2, 1);
    chk(rd2 == 32'h0000_7654, "R5 engine sees new high word", rd2, 32'h0000_7654);

    // R7: host served next despite engine streaming
    fork
      h_op(0, 0, 0, 26, 0, rd, w);
      begin
        @(negedge clk);
        e_req = 1; e_we = 0; e_pair = 0; e_addr = 7'd5;
        repeat (4) @(negedge clk);
        e_req = 0;
      end
    join
    chk(w == 1, "R7 host waits one access", w, 1);
    chk(rd == 32'h0000_BEEF, "R7 host data", rd, 32'h0000_BEEF);

    // R8: map corners
    h_op(0, 1, 0, 119, 32'h7777, rd, w); b_write(0, 119, 32'h7777);
    h_op(0, 1, 0, 126, 32'h6666, rd, w); b_write(0, 126, 32'h6666);
    h_op(0, 1, 0, 13,  32'h0D0D, rd, w); b_write(0, 13, 32'h0D0D);
    h_op(0, 0, 0, 119, 0, rd, w);
    chk(rd == 32'h7777, "R8 ch14 slot7", rd, 32'h7777);
    e_op(0, 0, 0, 126, 0, rd, w);
    chk(rd == 32'h6666, "R8 ch15 slot6", rd, 32'h6666);
    h_op(0, 0, 0, 13, 0, rd, w);
    chk(rd == 32'h0D0D, "R8 ch1 slot5", rd, 32'h0D0D);

    // R9/R10: unimplemented slots
    h_op(0, 1, 0, 6,   32'hDEAD, rd, w);
    h_op(0, 1, 0, 111, 32'hDEAD, rd, w);
    h_op(0, 1, 1, 15,  32'hDEAD_DEAD, rd, w);
    h_op(0, 0, 0, 6, 0, rd, w);
    chk(rd == 0, "R9 ch0 slot6 reads zero", rd, 0);
    e_op(0, 0, 0, 111, 0, rd, w);
    chk(rd == 0, "R9 ch13 slot7 reads zero", rd, 0);
    h_op(0, 0, 1, 14, 0, rd, w);
    chk(rd == 0, "R10 void pair ignored", rd, 0);
    h_op(0, 0, 1, 12, 0, rd, w);
    chk(rd == b_expect(1, 12), "R10 neighbours intact", rd, b_expect(1, 12));
    h_op(0, 0, 0, 16, 0, rd, w);
    chk(rd == b_expect(0, 16), "R10 next channel intact", rd, b_expect(0, 16));

    // Random single-port traffic: R2 R3 R4 R8 R9 R10
    for (int i = 0; i < 400; i++) begin
      bit eng, we, pair;
      int a;
      logic [31:0] d;
      eng = 1'($urandom);
      we = 1'($urandom);
      pair = 1'($urandom);
      a = int'($urandom % 128);
      d = $urandom;
      if (eng) e_op(0, we, pair, a, d, rd, w);
      else     h_op(0, we, pair, a, d, rd, w);
      chk(w == (pair ? 1 : 0), "R4 random wait count", w, pair ? 1 : 0);
      if (we) b_write(pair, a, d);
      else chk(rd == b_expect(pair, a), "R2 R3 R9 random read", rd, b_expect(pair, a));
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule